// File: doc/BRIEF.md
# Guarded System Clock Divider

This block divides the master clock by a power of two and sends the result downstream as a single-cycle clock-enable pulse. All synchronous logic in the divided domain advances on that pulse. The ratio is held in an 8-bit control register with a simple write/read port. The register has an arm flag in its top bit and a 4-bit ratio code in its low nibble.

A stray write must not retune the system clock, so changing the ratio takes a two-step sequence. First, software writes the exact arm pattern, which raises the flag. Then, within a short fixed window, it writes the new code. The flag drops by itself when the window runs out, or at once when a code is written. A new ratio never cuts a period short: the period already running completes at the old length, and the next period uses the new length.

Top module: `clkdiv_guard`

## Requirements
- R1: After reset the register reads 0x00 (arm flag clear, code 0, so divide by 1) and `tick_o` is high on every cycle.
- R2: A write of exactly 0x80 while the flag is clear sets bit 7. A write of any other value while the flag is clear, for example 0x81, leaves the flag clear.
- R3: Once set, the flag reads 1 for exactly four cycles and then clears by itself. A code write is accepted only on one of the four clock edges that follow the arming edge.
- R4: While the flag is set, a write with bit 7 = 0 loads bits 3:0 into the code field and clears the flag on the same edge.
- R5: While the flag is set, a write with bit 7 = 1 (including 0x80 again) has no effect. It neither restarts the four-cycle window nor clears the flag, and the code is unchanged.
- R6: While the flag is clear, a write with bit 7 = 0 leaves the code unchanged.
- R7: A code c from 0 to 8 divides by 2^c. In steady state, `tick_o` is a one-cycle pulse every 2^c master cycles.
- R8: A code write of a value from 9 to 15 clears the flag but keeps the previous code and ratio.
- R9: A ratio change takes effect at a period boundary. The period in progress finishes at the old length, and the next period has the new length.
- R10: Bits 6:4 always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data: bit 7 arm flag, bits 3:0 ratio code |
| rd_data | output | 8 | Register readback: {flag, 3'b000, code} |
| tick_o | output | 1 | Divided clock-enable pulse |

## Verification
The embedded assertions check the following on every cycle:
- the flag never stays high longer than the window;
- the flag rises only after an exact arm pattern;
- the code changes only on an accepted code write and never holds a reserved value;
- the divider count stays within the active period;
- the active ratio switches only on a boundary pulse.

Only the bench scenarios can show the full timing:
- the exact edge on which the window closes;
- that re-arming does not stretch the window;
- that the measured pulse spacing equals 2^c for every legal code;
- the old-then-new period lengths around a mid-period change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int          CTRL_W     = 8;
  localparam int          FLAG_BIT   = 7;
  localparam int          CODE_W     = 4;
  localparam logic [7:0]  ARM_PATTERN = 8'h80;

  typedef logic [CTRL_W-1:0] ctrl_word_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/clkdiv_unlock.sv
module clkdiv_unlock
  import clkdiv_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  ctrl_word_t wr_data,
  output logic       armed_o,
  output logic       code_wr_o
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int AW = CW + 1;

  logic          armed_q, armed_d;
  logic [CW-1:0] left_q, left_d;
  logic          arm_hit;
  logic          reg_en;

  assign arm_hit   = wr_en && (wr_data == ARM_PATTERN);
  assign code_wr_o = armed_q && wr_en && !wr_data[FLAG_BIT];
  assign armed_o   = armed_q;
  assign reg_en    = armed_q || arm_hit;

  always_comb begin
    armed_d = armed_q;
    left_d  = left_q;
    if (!armed_q) begin
      if (arm_hit) begin
        armed_d = 1'b1;
        left_d  = CW'(WIN_CYC - 1);
      end
    end else if (code_wr_o) begin
      armed_d = 1'b0;
    end else if (left_q == '0) begin
      armed_d = 1'b0;
    end else begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (reg_en) begin
      armed_q <= armed_d;
      left_q  <= left_d;
    end
  end

  // Window age checker
  logic [AW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age_q <= '0;
    else if (!armed_q) age_q <= '0;
    else if (age_q != '1) age_q <= age_q + 1'b1;
  end

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (age_q < AW'(WIN_CYC)));

  // R2
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(arm_hit));

  // R4
  code_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr_o |=> !armed_q);
endmodule

// File: rtl/clkdiv_codereg.sv
module clkdiv_codereg
  import clkdiv_pkg::*;
#(
  parameter int MAX_CODE = 8,
  parameter int RST_CODE = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  code_wr,
  input  code_t code_in,
  output code_t code_o
);
  code_t code_q, code_d;
  logic  legal;
  logic  reg_en;

  assign legal  = (code_in <= CODE_W'(MAX_CODE));
  assign reg_en = code_wr && legal;
  assign code_o = code_q;

  always_comb begin
    code_d = code_q;
    if (reg_en) code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= CODE_W'(RST_CODE);
    else if (reg_en) code_q <= code_d;
  end

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(MAX_CODE));

  // R6
  code_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(code_wr));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int MAX_CODE = 8,
  parameter int RST_CODE = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_req,
  output logic  tick_o
);
  localparam int NW = (MAX_CODE > 0) ? MAX_CODE : 1;

  code_t         act_q, act_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] limit;
  logic          wrap;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      limit[i] = (CODE_W'(i) < act_q);
    end
  end

  assign wrap   = (cnt_q == limit);
  assign tick_o = wrap;

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      act_d = code_req;
    end else begin
      cnt_d = cnt_q + 1'b1;
      act_d = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= CODE_W'(RST_CODE);
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R9
  ratio_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(tick_o));
endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
  import clkdiv_pkg::*;
#(
  parameter int WIN_CYC     = 4,
  parameter int MAX_CODE    = 8,
  parameter int RST_CODE    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       tick_o
);
  logic  rst_sync_n;
  logic  armed;
  logic  code_wr;
  code_t code;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= 1'b1;
      end
      assign rst_sync_n = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = s_q[SYNC_STAGES-1];
    end
  endgenerate

  clkdiv_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .armed_o   (armed),
    .code_wr_o (code_wr)
  );

  clkdiv_codereg #(.MAX_CODE(MAX_CODE), .RST_CODE(RST_CODE)) u_code (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_wr (code_wr),
    .code_in (wr_data[CODE_W-1:0]),
    .code_o  (code)
  );

  clkdiv_counter #(.MAX_CODE(MAX_CODE), .RST_CODE(RST_CODE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .code_req (code),
    .tick_o   (tick_o)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[FLAG_BIT]       = armed;
    rd_data[CODE_W-1:0]     = code;
  end

  // R10
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[6:4] == 3'b000);
endmodule

// File: tb/clkdiv_guard_test.sv
module clkdiv_guard_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tick_o;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  clkdiv_guard uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick_o  (tick_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick(output int t);
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int cur;
    int t0, t1, t2, t3;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    for (int i = 0; i < 4; i++) begin
      chk("R1 tick every cycle", tick_o, 1);
      @(negedge clk);
    end

    // R2 non-exact pattern does not arm
    wr(8'h81);
    chk("R2 0x81 no arm", rd_data, 8'h00);
    wr(8'hC0);
    chk("R2 0xC0 no arm", rd_data, 8'h00);
    // R6 code write without arm ignored
    wr(8'h03);
    chk("R6 ignored disarmed", rd_data, 8'h00);

    // R3/R4 window sweep
    cur = 0;
    for (int k = 0; k <= 6; k++) begin
      int nv;
      nv = k + 1;
      wr(8'h80);
      chk("R2 arm set", rd_data, 8'h80 | cur);
      idle(k);
      chk("R3 flag during/after window", rd_data[7], (k <= 3) ? 1 : 0);
      wr(nv[7:0]);
      if (k <= 3) cur = nv;
      chk("R4 code accept by window", rd_data, cur);
      idle(5);
    end

    // R5 re-arm neither extends nor clears
    wr(8'h80);
    idle(1);
    wr(8'h80);
    chk("R5 flag kept after rearm", rd_data, 8'h80 | cur);
    wr(8'h8F);
    chk("R5 bit7 write no effect", rd_data, 8'h80 | cur);
    idle(1);
    chk("R5 window not extended", rd_data, cur);
    wr(8'h02);
    chk("R5 late write ignored", rd_data, cur);

    // R8 reserved codes
    for (int c = 9; c <= 15; c++) begin
      wr(8'h80);
      wr(c[7:0]);
      chk("R8 reserved holds code", rd_data, cur);
    end

    // R10 pad bits
    wr(8'h80);
    wr(8'h72);
    cur = 2;
    chk("R10 pad bits read zero", rd_data, 8'h02);

    // R7 ratio sweep
    for (int s = 0; s <= 8; s++) begin
      wr(8'h80);
      wr(s[7:0]);
      chk("R4 code loaded", rd_data, s);
      wait_tick(t1);
      wait_tick(t2);
      wait_tick(t3);
      chk("R7 first new period", t2 - t1, 1 << s);
      chk("R7 steady period", t3 - t2, 1 << s);
    end

    // R9 mid-period change 4 -> 32
    wr(8'h80); wr(8'h02);
    wait_tick(t0); wait_tick(t0);
    wr(8'h80); wr(8'h05);
    wait_tick(t1); wait_tick(t2);
    chk("R9 old period finishes", t1 - t0, 4);
    chk("R9 new period after boundary", t2 - t1, 32);

    // R9 mid-period change 32 -> 1
    wait_tick(t0);
    wr(8'h80); wr(8'h00);
    wait_tick(t1); wait_tick(t2);
    chk("R9 long period finishes", t1 - t0, 32);
    chk("R9 short period after boundary", t2 - t1, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule